// File: doc/BRIEF.md
# Target Read Return Formatter

This block answers target read requests for a 32-bit register or memory backend that sits behind a 64-bit read-return path. A request brings a byte address, a tag, eight byte enables laid out over the whole aligned quadword, and an 8-bit control word. The block takes one request at a time. It reads one or two dwords from the backend and builds a 64-bit response aligned to the quadword. The tag and the control word go back unchanged with the data. Bit 0 of the control word asks for both dwords of the quadword. That happens for an aligned quadword read or for a dword read that spans the dword boundary. When the bit is clear, only the dword picked by address bit 2 is fetched.

Every backend read strobe carries a 4-bit lane mask taken from the matching half of the byte enables. A backend whose reads have side effects can therefore leave untouched any byte that was not requested. Bytes whose enable is clear come back as zero, and so does the half of the quadword that was not read.

The controller walks five states. ST_IDLE accepts a request. ST_ISSUE strobes the first dword. ST_COLLECT captures the first dword and, for a two-dword fetch, strobes the upper dword. ST_COLLECT_HI captures the upper dword. ST_RESPOND drives the one-cycle valid pulse. The transitions are:
- ST_IDLE to ST_ISSUE on a transfer.
- ST_ISSUE to ST_COLLECT always.
- ST_COLLECT to ST_COLLECT_HI for a two-dword fetch, otherwise ST_COLLECT to ST_RESPOND.
- ST_COLLECT_HI to ST_RESPOND always.
- ST_RESPOND to ST_IDLE always.
- Any state to ST_IDLE on reset.

Top module: `rdret_formatter`

## Requirements
- R1: A request transfers on a clock edge where req_en and req_accept are both high. req_accept is high only in the idle state. It is low from the cycle after a transfer until the response pulse has ended, and with req_en low no backend read is ever issued.
- R2: With control bit 0 clear, exactly one backend strobe is issued. bk_addr is the request address with bits 1:0 zero and bit 2 kept.
- R3: With control bit 0 set, two strobes are issued on consecutive cycles. The first has bk_addr bit 2 = 0 and the second has bk_addr bit 2 = 1.
- R4: A single dword read with address bit 2 = 1 returns its data in rsp_data[63:32]. With address bit 2 = 0 it returns its data in rsp_data[31:0]. The half that was not read is zero.
- R5: Enable bit n qualifies byte n of the quadword (bits 8n+7:8n). A strobe to the lower dword carries bk_lane = req_be[3:0], and a strobe to the upper dword carries bk_lane = req_be[7:4].
- R6: Every response byte whose enable is clear is zero. Every byte whose enable is set equals the backend byte in the matching lane.
- R7: rsp_ctl equals the full 8-bit control word of the request, held from the transfer through the response.
- R8: rsp_tag equals the 4-bit tag of the request.
- R9: rsp_valid is high for exactly one cycle per request.
- R10: Count edges from the transfer edge. rsp_valid is high in the third cycle after it for a one-dword read and in the fourth cycle for a two-dword read. Data, tag and control are valid in that same cycle.
- R11: Reset abandons any pending request. It drives rsp_valid and bk_rd low, clears rsp_data, rsp_tag and rsp_ctl, and leaves req_accept high once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_en | input | 1 | Read request present |
| req_accept | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address of the request, bits 1:0 zero |
| req_tag | input | TAG_W | Request tag |
| req_be | input | 8 | Byte enables over the aligned quadword |
| req_ctl | input | CTL_W | Control word; bit 0 requests both dwords |
| bk_rd | output | 1 | Backend read strobe |
| bk_addr | output | ADDR_W | Backend dword byte address |
| bk_lane | output | 4 | Byte lanes read by this strobe |
| bk_rdata | input | 32 | Backend data, one cycle after the strobe |
| rsp_valid | output | 1 | One-cycle response valid |
| rsp_data | output | 64 | Quadword-aligned response data |
| rsp_tag | output | TAG_W | Echoed tag |
| rsp_ctl | output | CTL_W | Echoed control word |

## Verification
Each result is due at a fixed cycle, counted from the transfer edge. req_accept falls in the first cycle after that edge. The first backend strobe is seen in the same cycle, and for two-dword reads the second strobe follows one cycle later. The response pulse comes in cycle three for one-dword reads and in cycle four for two-dword reads, and it is gone one cycle after that. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the transfer, and it requires the pulse to land on exactly the expected count before it compares data, tag and control. It logs backend strobes at the rising edge the backend itself samples, so that their order, spacing and lane masks can be checked once the response is done.

// File: rtl/rdret_pkg.sv
`timescale 1ns/1ps
package rdret_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_COLLECT,
        ST_COLLECT_HI,
        ST_RESPOND
    } rdret_state_e;

endpackage

// File: rtl/rdret_ctrl.sv
`timescale 1ns/1ps
module rdret_ctrl
    import rdret_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_en,
    input  logic req_two,
    input  logic req_hi,
    output logic req_accept,
    output logic load,
    output logic rd_strobe,
    output logic rd_hi,
    output logic cap,
    output logic cap_hi,
    output logic rsp_valid,
    output logic dbl
);

    rdret_state_e state_q, state_d;
    logic         dbl_q, hi_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request shape captured at transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbl_q <= 1'b0;
            hi_q  <= 1'b0;
        end else if (load) begin
            dbl_q <= req_two;
            hi_q  <= req_hi & ~req_two;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_en) state_d = ST_ISSUE;
            ST_ISSUE:      state_d = ST_COLLECT;
            ST_COLLECT:    state_d = dbl_q ? ST_COLLECT_HI : ST_RESPOND;
            ST_COLLECT_HI: state_d = ST_RESPOND;
            ST_RESPOND:    state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_accept = 1'b0;
        load       = 1'b0;
        rd_strobe  = 1'b0;
        rd_hi      = 1'b0;
        cap        = 1'b0;
        cap_hi     = 1'b0;
        rsp_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_accept = 1'b1;
                load       = req_en;
            end
            ST_ISSUE: begin
                rd_strobe = 1'b1;
                rd_hi     = hi_q;
            end
            ST_COLLECT: begin
                cap       = 1'b1;
                cap_hi    = hi_q;
                rd_strobe = dbl_q;
                rd_hi     = dbl_q;
            end
            ST_COLLECT_HI: begin
                cap    = 1'b1;
                cap_hi = 1'b1;
            end
            ST_RESPOND: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign dbl = dbl_q;

    // R1: accept drops right after a transfer
    p_accept_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_accept) |=> !req_accept)
        else $error("p_accept_drop_r1");

    // R9: valid is a single-cycle pulse
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid)
        else $error("p_valid_pulse_r9");

    // R11: leaving reset lands in idle with nothing pending
    p_reset_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_accept && !rsp_valid && !rd_strobe))
        else $error("p_reset_idle_r11");

endmodule

// File: rtl/rdret_lane.sv
`timescale 1ns/1ps
module rdret_lane #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4,
    localparam int OFFS  = $clog2(LANES),
    localparam int QB    = 2 * LANES
) (
    input  logic [ADDR_W-1:OFFS+1] addr_hi,
    input  logic [QB-1:0]          be_q,
    input  logic                   rd_hi,
    output logic [ADDR_W-1:0]      bk_addr,
    output logic [LANES-1:0]       bk_lane
);

    assign bk_addr = {addr_hi, rd_hi, {OFFS{1'b0}}};
    assign bk_lane = rd_hi ? be_q[QB-1:LANES] : be_q[LANES-1:0];

endmodule

// File: rtl/rdret_assemble.sv
`timescale 1ns/1ps
module rdret_assemble #(
    parameter int DW    = 32,
    localparam int LANES = DW / 8,
    localparam int QB    = 2 * LANES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            cap,
    input  logic            cap_hi,
    input  logic [QB-1:0]   be_q,
    input  logic [DW-1:0]   rdata,
    output logic [2*DW-1:0] qword
);

    logic [7:0] byte_q [QB];

    for (genvar b = 0; b < QB; b++) begin : g_byte
        localparam bit UPPER = (b >= LANES);
        localparam int SRC   = (b % LANES) * 8;

        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                byte_q[b] <= 8'h00;
            else if (cap && (cap_hi == UPPER))
                byte_q[b] <= be_q[b] ? rdata[SRC +: 8] : 8'h00;
        end

        assign qword[b*8 +: 8] = byte_q[b];
    end

endmodule

// File: rtl/rdret_formatter.sv
`timescale 1ns/1ps
module rdret_formatter #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4,
    parameter int CTL_W  = 8,
    parameter int DW     = 32,
    localparam int LANES = DW / 8,
    localparam int QB    = 2 * LANES,
    localparam int OFFS  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    output logic              req_accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [QB-1:0]     req_be,
    input  logic [CTL_W-1:0]  req_ctl,
    output logic              bk_rd,
    output logic [ADDR_W-1:0] bk_addr,
    output logic [LANES-1:0]  bk_lane,
    input  logic [DW-1:0]     bk_rdata,
    output logic              rsp_valid,
    output logic [2*DW-1:0]   rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [CTL_W-1:0]  rsp_ctl
);

    logic                   load, rd_hi, cap, cap_hi, dbl;
    logic [ADDR_W-1:OFFS+1] addr_hi_q;
    logic [QB-1:0]          be_q;
    logic [TAG_W-1:0]       tag_q;
    logic [CTL_W-1:0]       ctl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi_q <= '0;
            be_q      <= '0;
            tag_q     <= '0;
            ctl_q     <= '0;
        end else if (load) begin
            addr_hi_q <= req_addr[ADDR_W-1:OFFS+1];
            be_q      <= req_be;
            tag_q     <= req_tag;
            ctl_q     <= req_ctl;
        end
    end

    rdret_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_en     (req_en),
        .req_two    (req_ctl[0]),
        .req_hi     (req_addr[OFFS]),
        .req_accept (req_accept),
        .load       (load),
        .rd_strobe  (bk_rd),
        .rd_hi      (rd_hi),
        .cap        (cap),
        .cap_hi     (cap_hi),
        .rsp_valid  (rsp_valid),
        .dbl        (dbl)
    );

    rdret_lane #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lane (
        .addr_hi (addr_hi_q),
        .be_q    (be_q),
        .rd_hi   (rd_hi),
        .bk_addr (bk_addr),
        .bk_lane (bk_lane)
    );

    rdret_assemble #(.DW(DW)) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (load),
        .cap    (cap),
        .cap_hi (cap_hi),
        .be_q   (be_q),
        .rdata  (bk_rdata),
        .qword  (rsp_data)
    );

    assign rsp_tag = tag_q;
    assign rsp_ctl = ctl_q;

    // R2: requests carry dword-aligned byte addresses
    p_addr_dword_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_en |-> (req_addr[OFFS-1:0] == '0))
        else $error("p_addr_dword_r2");

    // R3: a lower strobe of a two-dword fetch is followed by the upper one
    p_hi_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_rd && dbl && !bk_addr[OFFS]) |=> (bk_rd && bk_addr[OFFS]))
        else $error("p_hi_follows_r3");

    // R7 R8: echoed fields do not move while a request is in flight
    p_echo_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_accept && !$past(req_accept)) |-> ($stable(rsp_ctl) && $stable(rsp_tag)))
        else $error("p_echo_hold_r7");

endmodule

// File: tb/rdret_formatter_tb.sv
`timescale 1ns/1ps
module rdret_formatter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_en = 1'b0;
    logic        req_accept;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_tag = '0;
    logic [7:0]  req_be = '0;
    logic [7:0]  req_ctl = '0;
    logic        bk_rd;
    logic [31:0] bk_addr;
    logic [3:0]  bk_lane;
    logic [31:0] bk_rdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic [3:0]  rsp_tag;
    logic [7:0]  rsp_ctl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rdret_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_accept(req_accept),
        .req_addr(req_addr), .req_tag(req_tag), .req_be(req_be), .req_ctl(req_ctl),
        .bk_rd(bk_rd), .bk_addr(bk_addr), .bk_lane(bk_lane), .bk_rdata(bk_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag), .rsp_ctl(rsp_ctl)
    );

    function automatic logic [31:0] memw(int i);
        logic [31:0] k;
        k = 32'(i + 1);
        return k * 32'h9E37_79B9;
    endfunction

    function automatic logic [31:0] lmask(logic [3:0] l);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{l[b]}};
        return m;
    endfunction

    // backend model: data one cycle after the strobe; strobe log
    int          cyc = 0;
    int          log_n = 0;
    logic [31:0] log_addr [4];
    logic [3:0]  log_lane [4];
    int          log_cyc  [4];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bk_rd) begin
            bk_rdata <= memw(int'(bk_addr[5:2]));
            if (log_n < 4) begin
                log_addr[log_n] <= bk_addr;
                log_lane[log_n] <= bk_lane;
                log_cyc[log_n]  <= cyc;
            end
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // stimulus vectors: {addr[5:0], be, ctl, tag}
    localparam logic [25:0] VEC [8] = '{
        {6'h00, 8'h0F, 8'h00, 4'h1},
        {6'h04, 8'hF0, 8'h00, 4'h2},
        {6'h04, 8'h30, 8'h00, 4'h3},
        {6'h08, 8'hFF, 8'h01, 4'h4},
        {6'h08, 8'h3C, 8'h81, 4'h5},
        {6'h10, 8'h06, 8'h5A, 4'h6},
        {6'h3C, 8'hC0, 8'h00, 4'hF},
        {6'h18, 8'h00, 8'h01, 4'h0}
    };

    task automatic run_req(input logic [5:0] a, input logic [7:0] be, input logic [7:0] ctl, input logic [3:0] tag);
        logic [63:0] exp_d;
        logic [31:0] lo, hi;
        int          q, lat, exp_lat, exp_n;
        q  = int'(a[5:3]) * 2;
        lo = memw(q);
        hi = memw(q + 1);
        if (ctl[0])    exp_d = {hi & lmask(be[7:4]), lo & lmask(be[3:0])};
        else if (a[2]) exp_d = {hi & lmask(be[7:4]), 32'h0};
        else           exp_d = {32'h0, lo & lmask(be[3:0])};
        exp_lat = ctl[0] ? 4 : 3;
        exp_n   = ctl[0] ? 2 : 1;

        @(negedge clk);
        log_n    = 0;
        req_addr = {26'h0, a};
        req_be   = be;
        req_ctl  = ctl;
        req_tag  = tag;
        req_en   = 1'b1;
        chk(req_accept == 1'b1, "R1 accept high in idle", 64'(req_accept), 64'h1);
        @(negedge clk);
        req_en = 1'b0;
        chk(req_accept == 1'b0, "R1 accept low after transfer", 64'(req_accept), 64'h0);
        lat = 1;
        while (!rsp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, "R10 response latency", 64'(lat), 64'(exp_lat));
        chk(rsp_data == exp_d, "R4 R6 response data", rsp_data, exp_d);
        chk(rsp_tag == tag, "R8 tag echo", 64'(rsp_tag), 64'(tag));
        chk(rsp_ctl == ctl, "R7 control echo", 64'(rsp_ctl), 64'(ctl));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 valid single cycle", 64'(rsp_valid), 64'h0);
        chk(req_accept == 1'b1, "R1 accept back after response", 64'(req_accept), 64'h1);
        chk(log_n == exp_n, "R2 R3 strobe count", 64'(log_n), 64'(exp_n));
        if (ctl[0] && log_n == 2) begin
            chk(log_addr[0] == {26'h0, a[5:3], 3'b000}, "R3 first strobe lower dword", 64'(log_addr[0]), 64'({a[5:3], 3'b000}));
            chk(log_addr[1] == {26'h0, a[5:3], 3'b100}, "R3 second strobe upper dword", 64'(log_addr[1]), 64'({a[5:3], 3'b100}));
            chk(log_cyc[1] == log_cyc[0] + 1, "R3 strobes consecutive", 64'(log_cyc[1] - log_cyc[0]), 64'h1);
            chk(log_lane[0] == be[3:0], "R5 lower lanes", 64'(log_lane[0]), 64'(be[3:0]));
            chk(log_lane[1] == be[7:4], "R5 upper lanes", 64'(log_lane[1]), 64'(be[7:4]));
        end else if (!ctl[0] && log_n == 1) begin
            chk(log_addr[0] == {26'h0, a[5:2], 2'b00}, "R2 strobe address", 64'(log_addr[0]), 64'({a[5:2], 2'b00}));
            chk(log_lane[0] == (a[2] ? be[7:4] : be[3:0]), "R5 single lanes", 64'(log_lane[0]), 64'(a[2] ? be[7:4] : be[3:0]));
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: state during and after reset
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0 && bk_rd == 1'b0, "R11 quiet in reset", {62'h0, rsp_valid, bk_rd}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_accept == 1'b1, "R11 accept after reset", 64'(req_accept), 64'h1);
        chk(rsp_data == 64'h0 && rsp_tag == 4'h0 && rsp_ctl == 8'h0, "R11 fields cleared",
            rsp_data | 64'(rsp_tag) | 64'(rsp_ctl), 64'h0);

        // R1: idle with req_en low issues nothing
        log_n = 0;
        repeat (4) @(negedge clk);
        chk(log_n == 0, "R1 no strobe without request", 64'(log_n), 64'h0);

        for (int i = 0; i < 8; i++)
            run_req(VEC[i][25:20], VEC[i][19:12], VEC[i][11:4], VEC[i][3:0]);

        // R11: reset in the middle of a two-dword fetch
        @(negedge clk);
        req_addr = 32'h20; req_be = 8'hFF; req_ctl = 8'h01; req_tag = 4'h9;
        req_en = 1'b1;
        @(negedge clk);
        req_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        log_n = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R11 no response after reset", 64'(rsp_valid), 64'h0);
        end
        chk(log_n == 0, "R11 no strobe after reset", 64'(log_n), 64'h0);
        chk(req_accept == 1'b1 && rsp_tag == 4'h0, "R11 idle and cleared", {59'h0, req_accept, rsp_tag}, 64'h10);

        // back in service after the aborted request
        run_req(6'h24, 8'hF0, 8'h00, 4'hA);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule